// File: doc/BRIEF.md
# Core Run/Halt Controller

This block is a small memory-mapped peripheral that starts and stops the cores of a two-core processor. Software writes an 8-bit command byte to a single control register. The block decodes the byte into a halt line for each core and a task-select flag. The default core always runs. The second core comes out of reset halted. A run command for the second core releases it and sets the task-select flag in the same cycle. Software on either core polls that flag to learn which core owns the current task.

Software can read back a 32-entry per-core status table and an enable register. Both sit in a 32-byte window that is addressed by byte. Byte offset 0 holds the default core's entry and offset 1 holds the second core's entry. Offset 4 holds the enable register, and every other offset is reserved. The write side and the read side are independent address/data/valid channels with no back-pressure. A read returns its data one cycle after the address is accepted.

Top module: `core_run_ctrl`

## Requirements
- R1: While reset is held and right after it, halt1_o is 0, halt2_o is 1, the task-select flag is 0 and rd_valid_o is 0.
- R2: A write is accepted when wr_addr_valid_i and wr_data_valid_i are both high in one cycle and wr_addr_i equals 0x60000000. An accepted command 0x01 clears halt2_o and sets the task-select flag on the following clock edge.
- R3: An accepted command 0x00 sets halt2_o and leaves the task-select flag unchanged. An accepted command 0x07 clears the task-select flag and leaves halt2_o unchanged.
- R4: halt1_o is never asserted, whatever command is written (including 0x06).
- R5: The following leave halt2_o and the task-select flag unchanged: any other command byte, a write to another address, and a cycle where only one of the two write valids is high.
- R6: Each cycle with rd_addr_valid_i high produces exactly one cycle of rd_valid_o on the next cycle, and back-to-back reads are allowed. Read data shows the state from before any write accepted in the same cycle.
- R7: A status entry uses bit 0 for reset-vector mode (always 1 for both cores), bit 1 for specific-address mode (always 0) and bit 2 for halt. Offset 0 therefore reads 0x1, and offset 1 reads 0x1 or 0x5 according to halt2_o.
- R8: Offset 4 (address 0x60000004) returns the enable register, with the task-select flag in bit 0 and zeros elsewhere.
- R9: Reserved offsets (every offset other than 0, 1 and 4 within 0x60000000–0x6000001F) read as zero. Addresses outside that window also read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_addr_i | input | 32 | Write address |
| wr_addr_valid_i | input | 1 | Write address valid |
| wr_data_i | input | 8 | Command byte |
| wr_data_valid_i | input | 1 | Write data valid |
| rd_addr_i | input | 32 | Read address |
| rd_addr_valid_i | input | 1 | Read address valid |
| rd_data_o | output | 32 | Read data |
| rd_valid_o | output | 1 | Read data valid |
| halt1_o | output | 1 | Halt line of the default core |
| halt2_o | output | 1 | Halt line of the second core |

## Verification
Every result is due exactly one clock edge after its stimulus:
- the halt lines and the flag change on the edge that accepts the write;
- rd_data_o and rd_valid_o appear on the edge after the read address is accepted.

The bench drives inputs just after a falling edge and samples on the next falling edge. It therefore sees the value registered one rising edge later. Expected read data is computed from the bench's own state model when the read is issued, so the model does not yet include a write issued in the same cycle. That expected value is pushed into a queue, and a monitor pops it on the cycle rd_valid_o is high.

// File: rtl/core_run_pkg.sv
package core_run_pkg;
  localparam int unsigned CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_HALT_C2 = 8'h00;
  localparam logic [CMD_W-1:0] CMD_RUN_C2  = 8'h01;
  localparam logic [CMD_W-1:0] CMD_RUN_C1  = 8'h07;

  // Status entry, bit 2..0
  typedef struct packed {
    logic halt;
    logic at_addr;
    logic at_reset;
  } core_stat_t;

  localparam int unsigned STAT_W = $bits(core_stat_t);
endpackage

// File: rtl/run_cmd_dec.sv
module run_cmd_dec
  import core_run_pkg::*;
(
  input  logic             cmd_vld_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             run2_o,
  output logic             halt2_o,
  output logic             run1_o
);
  always_comb begin
    run2_o  = 1'b0;
    halt2_o = 1'b0;
    run1_o  = 1'b0;
    if (cmd_vld_i) begin
      unique case (cmd_i)
        CMD_RUN_C2:  run2_o  = 1'b1;
        CMD_HALT_C2: halt2_o = 1'b1;
        CMD_RUN_C1:  run1_o  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/run_state_regs.sv
module run_state_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run2_i,
  input  logic halt2_i,
  input  logic run1_i,
  output logic halt2_o,
  output logic task_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt2_o    <= 1'b1;
      task_sel_o <= 1'b0;
    end else if (run2_i) begin
      halt2_o    <= 1'b0;
      task_sel_o <= 1'b1;
    end else if (halt2_i) begin
      halt2_o    <= 1'b1;
    end else if (run1_i) begin
      task_sel_o <= 1'b0;
    end
  end
endmodule

// File: rtl/stat_read_port.sv
module stat_read_port
  import core_run_pkg::*;
#(
  parameter int unsigned          ADDR_W     = 32,
  parameter int unsigned          DATA_W     = 32,
  parameter logic [ADDR_W-1:0]    BASE_ADDR  = 32'h6000_0000,
  parameter int unsigned          TBL_DEPTH  = 32,
  parameter int unsigned          EN_OFFSET  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_addr_valid_i,
  input  logic              halt2_i,
  input  logic              task_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int unsigned OFF_W = $clog2(TBL_DEPTH);

  core_stat_t  stat_tbl [TBL_DEPTH];
  logic [OFF_W-1:0] off;
  logic             in_win;
  logic [DATA_W-1:0] rd_mux;

  for (genvar i = 0; i < TBL_DEPTH; i++) begin : g_tbl
    if (i == 0) begin : g_c1
      assign stat_tbl[i] = '{halt: 1'b0, at_addr: 1'b0, at_reset: 1'b1};
    end else if (i == 1) begin : g_c2
      assign stat_tbl[i] = '{halt: halt2_i, at_addr: 1'b0, at_reset: 1'b1};
    end else begin : g_rsvd
      assign stat_tbl[i] = '0;
    end
  end

  assign off    = rd_addr_i[OFF_W-1:0];
  assign in_win = (rd_addr_i[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);

  always_comb begin
    rd_mux = '0;
    if (in_win) begin
      if (off == OFF_W'(EN_OFFSET)) rd_mux[0] = task_sel_i;
      else                          rd_mux[STAT_W-1:0] = stat_tbl[off];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_addr_valid_i;
      if (rd_addr_valid_i) rd_data_o <= rd_mux;
    end
  end
endmodule

// File: rtl/core_run_ctrl.sv
module core_run_ctrl
  import core_run_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h6000_0000,
  parameter int unsigned       TBL_DEPTH = 32,
  parameter int unsigned       EN_OFFSET = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_addr_valid_i,
  input  logic [CMD_W-1:0]  wr_data_i,
  input  logic              wr_data_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_addr_valid_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              halt1_o,
  output logic              halt2_o
);
  logic wr_acc;
  logic run2, halt2_cmd, run1;
  logic task_sel;

  assign wr_acc = wr_addr_valid_i && wr_data_valid_i && (wr_addr_i == BASE_ADDR);

  run_cmd_dec u_dec (
    .cmd_vld_i (wr_acc),
    .cmd_i     (wr_data_i),
    .run2_o    (run2),
    .halt2_o   (halt2_cmd),
    .run1_o    (run1)
  );

  run_state_regs u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run2_i     (run2),
    .halt2_i    (halt2_cmd),
    .run1_i     (run1),
    .halt2_o    (halt2_o),
    .task_sel_o (task_sel)
  );

  stat_read_port #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .TBL_DEPTH (TBL_DEPTH),
    .EN_OFFSET (EN_OFFSET)
  ) u_rd (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .rd_addr_i       (rd_addr_i),
    .rd_addr_valid_i (rd_addr_valid_i),
    .halt2_i         (halt2_o),
    .task_sel_i      (task_sel),
    .rd_data_o       (rd_data_o),
    .rd_valid_o      (rd_valid_o)
  );

  // Default core is never stopped
  assign halt1_o = 1'b0;
endmodule

// File: rtl/core_run_ctrl_chk.sv
module core_run_ctrl_chk #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h6000_0000,
  parameter int unsigned       TBL_DEPTH = 32,
  parameter int unsigned       EN_OFFSET = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              wr_addr_valid_i,
  input logic [7:0]        wr_data_i,
  input logic              wr_data_valid_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              rd_addr_valid_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_valid_o,
  input logic              halt1_o,
  input logic              halt2_o,
  input logic              task_sel
);
  localparam int unsigned OFF_W = $clog2(TBL_DEPTH);

  logic acc, rsvd_rd;
  assign acc = wr_addr_valid_i && wr_data_valid_i && (wr_addr_i == BASE_ADDR);
  assign rsvd_rd = rd_addr_valid_i
                && (rd_addr_i[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W])
                && (rd_addr_i[OFF_W-1:0] > OFF_W'(1))
                && (rd_addr_i[OFF_W-1:0] != OFF_W'(EN_OFFSET));

  p_core1_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni) !halt1_o);

  p_run2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && wr_data_i == 8'h01) |=> (!halt2_o && task_sel));

  p_halt2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && wr_data_i == 8'h00) |=> (halt2_o && $stable(task_sel)));

  p_run1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && wr_data_i == 8'h07) |=> (!task_sel && $stable(halt2_o)));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc || !(wr_data_i inside {8'h00, 8'h01, 8'h07}))
      |=> ($stable(halt2_o) && $stable(task_sel)));

  p_rd_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_valid_i |=> rd_valid_o);

  p_rd_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_addr_valid_i |=> !rd_valid_o);

  p_reserved_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_rd |=> (rd_data_o == '0));
endmodule

bind core_run_ctrl core_run_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .BASE_ADDR (BASE_ADDR),
  .TBL_DEPTH (TBL_DEPTH),
  .EN_OFFSET (EN_OFFSET)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_addr_i       (wr_addr_i),
  .wr_addr_valid_i (wr_addr_valid_i),
  .wr_data_i       (wr_data_i),
  .wr_data_valid_i (wr_data_valid_i),
  .rd_addr_i       (rd_addr_i),
  .rd_addr_valid_i (rd_addr_valid_i),
  .rd_data_o       (rd_data_o),
  .rd_valid_o      (rd_valid_o),
  .halt1_o         (halt1_o),
  .halt2_o         (halt2_o),
  .task_sel        (task_sel)
);

// File: tb/core_run_ctrl_tb.sv
module core_run_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] BASE = 32'h6000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wr_addr = '0;
  logic        wr_addr_vld = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        wr_data_vld = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        rd_addr_vld = 1'b0;
  logic [31:0] rd_data;
  logic        rd_vld;
  logic        halt1, halt2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit m_halt2 = 1'b1;
  bit m_tsel  = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  core_run_ctrl u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .wr_addr_i       (wr_addr),
    .wr_addr_valid_i (wr_addr_vld),
    .wr_data_i       (wr_data),
    .wr_data_valid_i (wr_data_vld),
    .rd_addr_i       (rd_addr),
    .rd_addr_valid_i (rd_addr_vld),
    .rd_data_o       (rd_data),
    .rd_valid_o      (rd_vld),
    .halt1_o         (halt1),
    .halt2_o         (halt2)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [31:0] a);
    if (a[31:5] != BASE[31:5]) return 32'h0;
    case (a[4:0])
      5'd0:    return 32'h1;
      5'd1:    return {29'h0, m_halt2, 2'b01};
      5'd4:    return {31'h0, m_tsel};
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(logic [31:0] a, logic [7:0] d, bit av, bit dv);
    if (!(av && dv && a == BASE)) return;
    case (d)
      8'h01: begin m_halt2 = 1'b0; m_tsel = 1'b1; end
      8'h00: m_halt2 = 1'b1;
      8'h07: m_tsel = 1'b0;
      default: ;
    endcase
  endfunction

  task automatic do_write(string tag, logic [31:0] a, logic [7:0] d, bit av = 1, bit dv = 1);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_addr_vld = av; wr_data_vld = dv;
    @(negedge clk);
    wr_addr_vld = 1'b0; wr_data_vld = 1'b0;
    model_write(a, d, av, dv);
    check({tag, " halt2"}, {31'h0, halt2}, {31'h0, m_halt2});
    check("R4 halt1", {31'h0, halt1}, 32'h0);
  endtask

  // Issue reads on consecutive cycles, one per address
  task automatic do_reads(string tag, logic [31:0] addrs[$]);
    foreach (addrs[i]) begin
      @(negedge clk);
      rd_addr = addrs[i]; rd_addr_vld = 1'b1;
      exp_q.push_back(model_read(addrs[i]));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    rd_addr_vld = 1'b0;
    @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected rd_valid actual=1 expected=0");
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 halt1 in reset", {31'h0, halt1}, 32'h0);
    check("R1 halt2 in reset", {31'h0, halt2}, 32'h1);
    check("R1 rd_valid in reset", {31'h0, rd_vld}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 halt2 after reset", {31'h0, halt2}, 32'h1);
    do_reads("R1 R8 enable after reset", '{BASE + 32'd4});
    do_reads("R7 table reset", '{BASE, BASE + 32'd1});

    do_write("R2 run core2", BASE, 8'h01);
    do_reads("R2 R7 R8 after run2", '{BASE + 32'd1, BASE + 32'd4, BASE});

    do_write("R3 run core1", BASE, 8'h07);
    do_reads("R3 tsel cleared", '{BASE + 32'd4, BASE + 32'd1});

    do_write("R5 unknown code", BASE, 8'hAB);
    do_write("R5 wrong address", BASE + 32'd4, 8'h00);
    do_write("R5 addr valid only", BASE, 8'h00, 1, 0);
    do_write("R5 data valid only", BASE, 8'h00, 0, 1);
    do_reads("R5 state held", '{BASE + 32'd1, BASE + 32'd4});

    do_write("R2 run core2 again", BASE, 8'h01);
    do_write("R3 halt core2", BASE, 8'h00);
    do_reads("R3 tsel kept on halt", '{BASE + 32'd4, BASE + 32'd1});
    do_write("R4 halt core1 attempt", BASE, 8'h06);
    do_reads("R4 R5 core1 entry", '{BASE, BASE + 32'd4});

    do_reads("R9 reserved", '{BASE + 32'd2, BASE + 32'd5, BASE + 32'h1F,
                              BASE + 32'h20, 32'h5000_0000});
    do_reads("R6 burst", '{BASE, BASE + 32'd1, BASE + 32'd2,
                           BASE + 32'd3, BASE + 32'd4, BASE + 32'd5});

    // Read and write in the same cycle: read sees the prior state
    @(negedge clk);
    wr_addr = BASE; wr_data = 8'h01; wr_addr_vld = 1'b1; wr_data_vld = 1'b1;
    rd_addr = BASE + 32'd1; rd_addr_vld = 1'b1;
    exp_q.push_back(model_read(BASE + 32'd1));
    tag_q.push_back("R6 R7 read during write");
    @(negedge clk);
    wr_addr_vld = 1'b0; wr_data_vld = 1'b0; rd_addr_vld = 1'b0;
    model_write(BASE, 8'h01, 1, 1);
    check("R2 halt2 after concurrent write", {31'h0, halt2}, {31'h0, m_halt2});
    do_reads("R2 R8 after concurrent write", '{BASE + 32'd4});

    repeat (3) @(negedge clk);
    check("R6 all reads returned", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule